// File: doc/BRIEF.md
# Parallel Bus Transmit Serializer

The block takes bytes from a valid/ready input stream, each with a last flag, and sends them out over a parallel data bus. Software picks the bus width: 1, 2, 4 or 8 lines. Each byte takes 8, 4, 2 or 1 bus cycles, and the least significant group of bits goes out first. An optional per-byte bit reversal is applied before serialization.

A frame begins with a one-cycle start pulse, accepted only while `tx_ready` is high. The frame ends in one of two ways, chosen by configuration. In count mode it ends after a programmed number of bytes. In last-flag mode it ends after the byte that carries the upstream last flag.

While no frame is in progress, the bus shows a programmable idle pattern. The bus also shows that pattern while a frame is waiting for data. An optional strobe marks the cycles that carry data. When gating is enabled, an output clock enable is held low outside a frame. One cycle after the final group of bits has been driven, a one-cycle `frame_done` pulse marks the end of the frame.

Top module: `pbus_tx`

## Requirements
- R1: The width code selects the number of active lanes: 0 gives 1 lane, 1 gives 2, 2 gives 4 and 3 gives 8. Lanes above the active count are driven 0. The width, length, end mode, reversal and strobe enable are captured when the frame starts.
- R2: Each byte is sent from its least significant group upward, one group per cycle. Lane i carries bit (g*lanes + i) of the byte in group g. A byte occupies 8/lanes cycles. When a next byte is available, it follows the previous one with no gap.
- R3: With `cfg_reverse` = 1, bit 7 of each input byte is treated as bit 0 before serialization, and so on for the other bits.
- R4: With `cfg_end_on_last` = 0, the frame ends after `cfg_len` bytes (19 bits; 0 acts as 1). `in_last` is ignored, and no further byte is accepted in that frame.
- R5: With `cfg_end_on_last` = 1, the frame ends after the byte accepted with `in_last` = 1, and `cfg_len` is ignored.
- R6: Outside a frame, `bus_data` equals the low active-lane bits of `cfg_idle`, using the current width code, and `bus_strobe` is 0.
- R7: If input data runs out inside a frame, `bus_data` shows the masked idle value and `bus_strobe` is 0 until the next byte is accepted.
- R8: `bus_strobe` is 1 exactly in the cycles that drive data when the captured strobe enable is 1. It is never 1 when the strobe enable is 0.
- R9: `bus_clk_en` is 1 during a frame. Outside a frame it is 0 when `cfg_clk_gate_en` = 1 and 1 when `cfg_clk_gate_en` = 0.
- R10: `start` takes effect only while `tx_ready` = 1. `tx_ready` falls in the cycle after the start edge and stays low until the frame ends. `in_ready` is 0 while `tx_ready` = 1.
- R11: `frame_done` is a one-cycle pulse in the cycle after the final group was driven, and `tx_ready` returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame launch pulse |
| cfg_width_code | input | 2 | Lane count code (0..3 gives 1/2/4/8) |
| cfg_len | input | 19 | Bytes per frame in count mode |
| cfg_end_on_last | input | 1 | 1: end on the last flag, 0: end on the count |
| cfg_reverse | input | 1 | Reverse bit order within each byte |
| cfg_strobe_en | input | 1 | Enable the data strobe |
| cfg_clk_gate_en | input | 1 | Hold the clock enable low outside a frame |
| cfg_idle | input | 16 | Idle bus pattern |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_last | input | 1 | Input byte is the last of the frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| bus_data | output | 8 | Parallel output lanes |
| bus_strobe | output | 1 | Data-valid strobe |
| bus_clk_en | output | 1 | Output clock enable |
| tx_ready | output | 1 | No frame in progress; start is accepted |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
A byte accepted at clock edge k drives its first group in the cycle after k. Its last group appears 8/lanes - 1 cycles later. `frame_done` and the return of `tx_ready` follow one cycle after the last group. `tx_ready` falls one cycle after the start edge.

The bench drives inputs and samples outputs on the falling edge. Every output it reads is then already settled from the preceding rising edge. A monitor records each falling-edge sample, rebuilds bytes from the strobed groups with its own lane arithmetic, and requires the `frame_done` sample to come right after the final strobed sample.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WCODE_W = 2;
  localparam int unsigned GRP_W   = 3;

  typedef enum logic {PBT_IDLE = 1'b0, PBT_RUN = 1'b1} pbt_state_e;

  // number of active lanes for a width code
  function automatic logic [3:0] lanes_of(input logic [WCODE_W-1:0] code);
    return 4'd1 << code;
  endfunction

  // lane enable mask for a width code
  function automatic logic [BYTE_W-1:0] lane_mask(input logic [WCODE_W-1:0] code);
    logic [BYTE_W:0] m;
    m = ({{BYTE_W{1'b0}}, 1'b1} << lanes_of(code)) - 1'b1;
    return m[BYTE_W-1:0];
  endfunction

  // index of the final group of a byte for a width code
  function automatic logic [GRP_W-1:0] last_group(input logic [WCODE_W-1:0] code);
    logic [3:0] g;
    g = (4'd8 >> code) - 4'd1;
    return g[GRP_W-1:0];
  endfunction

  // bit-order reversal of one byte
  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/pbt_ctrl.sv
module pbt_ctrl
  import pbt_pkg::*;
#(
  parameter int LEN_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WCODE_W-1:0] cfg_width_code,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_end_on_last,
  input  logic               cfg_reverse,
  input  logic               cfg_strobe_en,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               has_byte,
  input  logic               grp_last,
  output logic               active,
  output logic               in_ready,
  output logic               accept,
  output logic               frame_end,
  output logic               done_q,
  output logic [WCODE_W-1:0] run_width,
  output logic               run_reverse,
  output logic               run_strobe_en
);

  pbt_state_e        state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  run_len_q;
  logic              run_eol_q;
  logic              cur_last_q;
  logic              launch;
  logic [LEN_W:0]    cnt_nxt;
  logic              byte_final;

  assign active     = (state_q == PBT_RUN);
  assign launch     = (state_q == PBT_IDLE) && start;
  assign in_ready   = active && (!has_byte || (grp_last && !cur_last_q));
  assign accept     = in_ready && in_valid;
  assign frame_end  = active && grp_last && cur_last_q;
  assign cnt_nxt    = {1'b0, cnt_q} + 1'b1;
  assign byte_final = run_eol_q ? in_last : (cnt_nxt >= {1'b0, run_len_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= PBT_IDLE;
      cnt_q         <= '0;
      run_len_q     <= '0;
      run_eol_q     <= 1'b0;
      run_width     <= 2'd3;
      run_reverse   <= 1'b0;
      run_strobe_en <= 1'b0;
      cur_last_q    <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (launch) begin
        state_q       <= PBT_RUN;
        cnt_q         <= '0;
        run_len_q     <= cfg_len;
        run_eol_q     <= cfg_end_on_last;
        run_width     <= cfg_width_code;
        run_reverse   <= cfg_reverse;
        run_strobe_en <= cfg_strobe_en;
        cur_last_q    <= 1'b0;
      end else if (frame_end) begin
        state_q <= PBT_IDLE;
      end
      if (accept) begin
        cnt_q      <= cnt_nxt[LEN_W-1:0];
        cur_last_q <= byte_final;
      end
    end
  end

endmodule

// File: rtl/pbt_lane_shift.sv
module pbt_lane_shift
  import pbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WCODE_W-1:0] width_code,
  input  logic               load,
  input  logic [BYTE_W-1:0]  load_byte,
  output logic               has_byte,
  output logic               grp_last,
  output logic [BYTE_W-1:0]  lane_bits
);

  logic [BYTE_W-1:0] shreg_q;
  logic [GRP_W-1:0]  grp_q;

  assign grp_last  = has_byte && (grp_q == '0);
  assign lane_bits = shreg_q & lane_mask(width_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      grp_q    <= '0;
      has_byte <= 1'b0;
    end else if (load) begin
      shreg_q  <= load_byte;
      grp_q    <= last_group(width_code);
      has_byte <= 1'b1;
    end else if (has_byte) begin
      if (grp_q == '0) begin
        has_byte <= 1'b0;
      end else begin
        shreg_q <= shreg_q >> lanes_of(width_code);
        grp_q   <= grp_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbt_bus_drive.sv
module pbt_bus_drive
  import pbt_pkg::*;
#(
  parameter int IDLE_W = 16
) (
  input  logic               active,
  input  logic               has_byte,
  input  logic [BYTE_W-1:0]  lane_bits,
  input  logic [WCODE_W-1:0] width_code,
  input  logic [IDLE_W-1:0]  idle_val,
  input  logic               strobe_en,
  input  logic               gate_en,
  output logic [BYTE_W-1:0]  bus_data,
  output logic               bus_strobe,
  output logic               bus_clk_en
);

  localparam int LANES = (IDLE_W < BYTE_W) ? IDLE_W : BYTE_W;

  logic [BYTE_W-1:0] mask;
  assign mask = lane_mask(width_code);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
    if (i < LANES) begin : g_idle
      assign bus_data[i] = mask[i] & (has_byte ? lane_bits[i] : idle_val[i]);
    end else begin : g_zero
      assign bus_data[i] = mask[i] & has_byte & lane_bits[i];
    end
  end

  assign bus_strobe = active && has_byte && strobe_en;
  assign bus_clk_en = active || !gate_en;

endmodule

// File: rtl/pbus_tx.sv
module pbus_tx
  import pbt_pkg::*;
#(
  parameter int LEN_W  = 19,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_width_code,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_end_on_last,
  input  logic              cfg_reverse,
  input  logic              cfg_strobe_en,
  input  logic              cfg_clk_gate_en,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [7:0]        bus_data,
  output logic              bus_strobe,
  output logic              bus_clk_en,
  output logic              tx_ready,
  output logic              frame_done
);

  logic               active;
  logic               accept;
  logic               frame_end;
  logic               has_byte;
  logic               grp_last;
  logic [WCODE_W-1:0] run_width;
  logic               run_reverse;
  logic               run_strobe_en;
  logic [WCODE_W-1:0] width_eff;
  logic [BYTE_W-1:0]  load_byte;
  logic [BYTE_W-1:0]  lane_bits;

  pbt_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .cfg_width_code  (cfg_width_code),
    .cfg_len         (cfg_len),
    .cfg_end_on_last (cfg_end_on_last),
    .cfg_reverse     (cfg_reverse),
    .cfg_strobe_en   (cfg_strobe_en),
    .in_valid        (in_valid),
    .in_last         (in_last),
    .has_byte        (has_byte),
    .grp_last        (grp_last),
    .active          (active),
    .in_ready        (in_ready),
    .accept          (accept),
    .frame_end       (frame_end),
    .done_q          (frame_done),
    .run_width       (run_width),
    .run_reverse     (run_reverse),
    .run_strobe_en   (run_strobe_en)
  );

  assign load_byte = run_reverse ? flip_byte(in_data) : in_data;
  assign width_eff = active ? run_width : cfg_width_code;
  assign tx_ready  = !active;

  pbt_lane_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .width_code (run_width),
    .load       (accept),
    .load_byte  (load_byte),
    .has_byte   (has_byte),
    .grp_last   (grp_last),
    .lane_bits  (lane_bits)
  );

  pbt_bus_drive #(.IDLE_W(IDLE_W)) u_drive (
    .active     (active),
    .has_byte   (has_byte),
    .lane_bits  (lane_bits),
    .width_code (width_eff),
    .idle_val   (cfg_idle),
    .strobe_en  (run_strobe_en),
    .gate_en    (cfg_clk_gate_en),
    .bus_data   (bus_data),
    .bus_strobe (bus_strobe),
    .bus_clk_en (bus_clk_en)
  );

endmodule

// File: rtl/pbus_tx_chk.sv
module pbus_tx_chk #(
  parameter int LEN_W  = 19,
  parameter int IDLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        cfg_width_code,
  input logic [LEN_W-1:0]  cfg_len,
  input logic              cfg_end_on_last,
  input logic              cfg_reverse,
  input logic              cfg_strobe_en,
  input logic              cfg_clk_gate_en,
  input logic [IDLE_W-1:0] cfg_idle,
  input logic [7:0]        in_data,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [7:0]        bus_data,
  input logic              bus_strobe,
  input logic              bus_clk_en,
  input logic              tx_ready,
  input logic              frame_done
);

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !bus_strobe); // R6

  AST_IDLE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && cfg_width_code == 2'd0) |-> (bus_data[7:1] == 7'd0)); // R6

  AST_GATE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && cfg_clk_gate_en) |-> !bus_clk_en); // R9

  AST_CKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> bus_clk_en); // R9

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && start) |=> !tx_ready); // R10

  AST_NO_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !in_ready); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R11

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (tx_ready && !$past(tx_ready))); // R11

endmodule

bind pbus_tx pbus_tx_chk #(.LEN_W(LEN_W), .IDLE_W(IDLE_W)) u_chk (.*);

// File: tb/pbus_tx_tb.sv
`timescale 1ns/1ps
module pbus_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cfg_width_code = 2'd3;
  logic [18:0] cfg_len = 19'd1;
  logic        cfg_end_on_last = 1'b0;
  logic        cfg_reverse = 1'b0;
  logic        cfg_strobe_en = 1'b1;
  logic        cfg_clk_gate_en = 1'b0;
  logic [15:0] cfg_idle = 16'hA5C3;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  bus_data;
  logic        bus_strobe;
  logic        bus_clk_en;
  logic        tx_ready;
  logic        frame_done;

  int checks = 0;
  int failures = 0;

  logic [7:0] src [0:7];
  logic [7:0] rx  [0:15];
  bit frame_over;

  always #10 clk = ~clk;

  pbus_tx u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int lanes_n(input int w); return 1 << w; endfunction
  function automatic int mask_n(input int w); return (1 << lanes_n(w)) - 1; endfunction
  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // one frame: producer feeds src[], monitor rebuilds bytes from strobed groups
  task automatic run_frame(input int w, input bit rev, input bit eol, input int len,
                           input bit sen, input int n, input int last_idx,
                           input int gap, input string tag);
    int n_exp, got, bad_idle, idle_seen, upper_bad, last_strobe_cyc, done_cyc, cyc;
    @(negedge clk);
    cfg_width_code = 2'(w); cfg_reverse = rev; cfg_end_on_last = eol;
    cfg_len = 19'(len); cfg_strobe_en = sen;
    frame_over = 1'b0;
    pulse_start();
    chk(tx_ready == 1'b0, "R10", {tag, " tx_ready after start"}, tx_ready, 0);
    n_exp = eol ? last_idx + 1 : ((len == 0) ? 1 : len);
    got = 0; bad_idle = 0; idle_seen = 0; upper_bad = 0;
    last_strobe_cyc = -1; done_cyc = -1;
    fork
      begin : producer
        int i, gl;
        i = 0; gl = gap;
        while (i < n && !frame_over) begin
          if (i == 1 && gl > 0) begin
            in_valid = 1'b0; gl--;
          end else begin
            in_valid = 1'b1; in_data = src[i]; in_last = (i == last_idx);
            if (in_ready) i++;
          end
          @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
      end
      begin : monitor
        int pos;
        logic [7:0] acc;
        pos = 0; acc = 8'h00; cyc = 0;
        while (!frame_over && cyc < 400) begin
          if (frame_done) begin
            done_cyc = cyc;
            chk(tx_ready == 1'b1, "R11", {tag, " tx_ready with done"}, tx_ready, 1);
            frame_over = 1'b1;
          end else if (bus_strobe) begin
            acc = acc | 8'((int'(bus_data) & mask_n(w)) << pos);
            if ((int'(bus_data) & ~mask_n(w)) != 0) upper_bad++;
            pos += lanes_n(w);
            if (pos >= 8) begin
              if (got < 16) rx[got] = acc;
              got++; acc = 8'h00; pos = 0;
            end
            last_strobe_cyc = cyc;
          end else if (!tx_ready && sen) begin
            idle_seen++;
            if (int'(bus_data) != (int'(cfg_idle) & mask_n(w))) bad_idle++;
          end
          if (!frame_over) begin
            @(negedge clk);
            cyc++;
          end
        end
      end
    join
    chk(done_cyc >= 0, "R11", {tag, " frame_done seen"}, done_cyc, 1);
    if (sen) begin
      chk(got == n_exp, eol ? "R5" : "R4", {tag, " bytes sent"}, got, n_exp);
      for (int k = 0; k < n_exp && k < got; k++) begin
        logic [7:0] e;
        e = rev ? rev8(src[k]) : src[k];
        chk(rx[k] == e, rev ? "R3" : "R2", {tag, " byte value"}, rx[k], e);
      end
      chk(done_cyc == last_strobe_cyc + 1, "R11", {tag, " done one cycle after last group"},
          done_cyc, last_strobe_cyc + 1);
      chk(upper_bad == 0, "R1", {tag, " unused lanes zero"}, upper_bad, 0);
      chk(bad_idle == 0, "R7", {tag, " idle value while starved"}, bad_idle, 0);
      if (gap > 0) chk(idle_seen > 0, "R7", {tag, " starved cycles observed"}, idle_seen, 1);
    end else begin
      chk(last_strobe_cyc == -1, "R8", {tag, " strobe stays low"}, last_strobe_cyc, -1);
    end
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10", {tag, " ready after frame"}, tx_ready, 1);
    chk(in_ready == 1'b0, "R10", {tag, " no input taken when idle"}, in_ready, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10", "reset tx_ready", tx_ready, 1);
    chk(in_ready == 1'b0, "R10", "reset in_ready", in_ready, 0);
    chk(frame_done == 1'b0, "R11", "reset frame_done", frame_done, 0);
    chk(bus_data == 8'hC3, "R6", "reset idle 8 lanes", bus_data, 8'hC3);
    chk(bus_strobe == 1'b0, "R6", "reset strobe", bus_strobe, 0);
  endtask

  task automatic t_idle_widths();
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); cfg_width_code = 2'(w); cfg_idle = 16'hFFFF;
      @(negedge clk);
      chk(int'(bus_data) == mask_n(w), "R6", "idle masked by width", bus_data, mask_n(w));
    end
    cfg_idle = 16'hA5C3;
  endtask

  task automatic t_busy_start_and_gate();
    int dc;
    @(negedge clk);
    cfg_width_code = 2'd0; cfg_len = 19'd1; cfg_end_on_last = 1'b0;
    cfg_reverse = 1'b0; cfg_strobe_en = 1'b1; cfg_clk_gate_en = 1'b1;
    @(negedge clk);
    chk(bus_clk_en == 1'b0, "R9", "gated outside frame", bus_clk_en, 0);
    pulse_start();
    chk(tx_ready == 1'b0, "R10", "busy after start", tx_ready, 0);
    chk(bus_clk_en == 1'b1, "R9", "clock enabled in frame", bus_clk_en, 1);
    chk(bus_data == 8'h01 && bus_strobe == 1'b0, "R7", "no data yet shows idle",
        {bus_strobe, bus_data}, 9'h001);
    pulse_start();
    chk(tx_ready == 1'b0, "R10", "second start while busy", tx_ready, 0);
    in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    dc = -1;
    for (int c = 0; c < 20 && dc < 0; c++) begin
      if (frame_done) dc = c;
      else @(negedge clk);
    end
    chk(dc == 8, "R11", "done after 8 one-lane groups", dc, 8);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(tx_ready == 1'b1 && frame_done == 1'b0, "R10", "busy start ignored, no new frame",
          {tx_ready, frame_done}, 2'b10);
    end
    chk(bus_clk_en == 1'b0, "R9", "gated again after frame", bus_clk_en, 0);
    cfg_clk_gate_en = 1'b0;
    @(negedge clk);
    chk(bus_clk_en == 1'b1, "R9", "ungated outside frame", bus_clk_en, 1);
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_widths();
    // R2/R4: 8 lanes, two bytes back to back
    src[0] = 8'hA5; src[1] = 8'h3C;
    run_frame(3, 0, 0, 2, 1, 2, 7, 0, "w8");
    // R1/R2: one lane, LSB first over 8 cycles
    src[0] = 8'hB2;
    run_frame(0, 0, 0, 1, 1, 1, 7, 0, "w1");
    // R3: four lanes with bit reversal
    src[0] = 8'h1E;
    run_frame(2, 1, 0, 1, 1, 1, 7, 0, "w4rev");
    // R4: count mode, last flag on byte 0 ignored, third byte not taken
    src[0] = 8'h81; src[1] = 8'h42; src[2] = 8'hFF;
    run_frame(1, 0, 0, 2, 1, 3, 0, 0, "count");
    // R5: last-flag mode, length 1 ignored
    src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h9C;
    run_frame(1, 0, 1, 1, 1, 3, 2, 0, "lastflag");
    // R4 with zero length acting as one
    src[0] = 8'h6D;
    run_frame(3, 0, 0, 0, 1, 1, 7, 0, "len0");
    // R7: starved input mid-frame
    src[0] = 8'hC1; src[1] = 8'h7E; src[2] = 8'h05;
    run_frame(3, 0, 0, 3, 1, 3, 7, 4, "starve");
    // R8: strobe disabled
    src[0] = 8'hF0;
    run_frame(3, 0, 0, 1, 0, 1, 7, 0, "nostrobe");
    t_busy_start_and_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule